// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of a five-stage pipeline, where the operand value should come from when an instruction reaches the execute stage. It compares the two source register numbers of the executing instruction with the destination register numbers of the two older instructions still in flight. The older instructions are the one in the memory stage and the one in the writeback stage. Each operand then receives a 2-bit select, plus the value picked by a 3:1 multiplexer. The value comes from the register-file read port, from the ALU result held in the memory stage, or from the data being written back.

A producer counts only when its write enable is set and its destination is not register zero, which always reads as zero. If both producers match the same source, the younger one, in the memory stage, wins, because it holds the newer value. A producer three or more instructions older needs no bypass: the register file writes in the first half of the cycle and reads in the second. The block has no state. Pipeline registers and load-use stall detection belong to neighbouring logic.

Top module: `fwd_unit_top`

## Requirements
- R1: `sel_a` is 2'b10 and `op_a` equals `exm_result` when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_src_a`.
- R2: `sel_b` is 2'b10 and `op_b` equals `exm_result` when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_src_b`.
- R3: `sel_a` is 2'b01 and `op_a` equals `wb_data` when the writeback producer qualifies for operand A (`wb_wr_en` 1, `wb_dst` nonzero, equal to `ex_src_a`) and the memory-stage producer does not.
- R4: `sel_b` is 2'b01 and `op_b` equals `wb_data` under the same condition as R3, applied to operand B and `ex_src_b`.
- R5: When both producers qualify for the same operand, the select is 2'b10 (the memory-stage result wins).
- R6: A producer whose destination is register 0 never causes forwarding, whatever its write enable.
- R7: A producer whose write enable is 0 never causes forwarding, whatever its destination.
- R8: When no producer qualifies for an operand, its select is 2'b00 and the operand equals the register-file value; the code 2'b11 is never produced.
- R9: The two operands are resolved independently; both may be forwarded in the same cycle, including from the same producer when both sources name one register.
- R10: `op_a` and `op_b` always equal the source named by their select: 00 register file, 10 memory-stage result, 01 writeback data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_AW | First source register number of the executing instruction |
| ex_src_b | input | REG_AW | Second source register number of the executing instruction |
| exm_wr_en | input | 1 | Memory-stage instruction writes a register |
| exm_dst | input | REG_AW | Destination register of the memory-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_AW | Destination register of the writeback-stage instruction |
| rf_data_a | input | DATA_W | Register-file value for operand A |
| rf_data_b | input | DATA_W | Register-file value for operand B |
| exm_result | input | DATA_W | ALU result held in the memory stage |
| wb_data | input | DATA_W | Data being written back |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| op_a | output | DATA_W | Selected value for operand A |
| op_b | output | DATA_W | Selected value for operand B |

## Verification
Immediate assertions check several properties whenever their inputs change: a select is never 2'b11, the memory-stage producer takes priority, a register-zero or write-disabled producer is never chosen, and each operand equals the value its select names. The bench's scenarios are needed to show other behaviour. They show that each hazard case produces exactly the right code, that both operands forward at once from one producer, and that the register-file path is taken when no producer qualifies. Directed cases cover these; a run of random register numbers, kept in a small range so that matches are frequent, is compared with a behavioural priority model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_WB    = 2'b01,
        SEL_EXM   = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic hit_exm;
        logic hit_wb;
    } hit_pair_t;

    function automatic fwd_sel_e pick_source(input hit_pair_t h);
        if (h.hit_exm)
            return SEL_EXM;
        else if (h.hit_wb)
            return SEL_WB;
        else
            return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic              wr_en,
    input  logic [REG_AW-1:0] dst,
    input  logic [REG_AW-1:0] src,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end

    always_comb begin : chk
        if (!$isunknown({wr_en, dst, src})) begin
            assert_zero_reg_never_R6: assert (!(hit && dst == ZERO_REG))
                else $error("register zero produced a bypass hit");
            assert_no_write_never_R7: assert (!(hit && !wr_en))
                else $error("write-disabled producer produced a hit");
        end
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  hit_pair_t hits,
    output fwd_sel_e  sel
);
    always_comb begin
        sel = pick_source(hits);
    end

    always_comb begin : chk
        if (!$isunknown(hits)) begin
            assert_legal_code_R8: assert (sel != fwd_sel_e'(2'b11))
                else $error("illegal select code");
            assert_young_wins_R5: assert (!(hits.hit_exm && sel != SEL_EXM))
                else $error("memory-stage producer lost priority");
            assert_idle_rf_R8: assert (hits != '0 || sel == SEL_RF)
                else $error("select not register file with no hit");
        end
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e           sel,
    input  logic [DATA_W-1:0]  rf_val,
    input  logic [DATA_W-1:0]  exm_val,
    input  logic [DATA_W-1:0]  wb_val,
    output logic [DATA_W-1:0]  y
);
    always_comb begin
        unique case (sel)
            SEL_EXM: y = exm_val;
            SEL_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end

    always_comb begin : chk
        if (!$isunknown({sel, rf_val, exm_val, wb_val})) begin
            assert_mux_value_R10: assert (
                (sel == SEL_EXM && y == exm_val) ||
                (sel == SEL_WB  && y == wb_val)  ||
                (sel == SEL_RF  && y == rf_val))
                else $error("operand value does not follow select");
        end
    end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic              exm_wr_en,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              wb_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_idx [NUM_OPS];
    logic [DATA_W-1:0] rf_val  [NUM_OPS];
    logic [DATA_W-1:0] op_val  [NUM_OPS];
    fwd_sel_e          sel_v   [NUM_OPS];
    hit_pair_t         hits    [NUM_OPS];

    assign src_idx[0] = ex_src_a;
    assign src_idx[1] = ex_src_b;
    assign rf_val[0]  = rf_data_a;
    assign rf_val[1]  = rf_data_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_lane
        fwd_match #(.REG_AW(REG_AW)) u_match_exm (
            .wr_en (exm_wr_en),
            .dst   (exm_dst),
            .src   (src_idx[i]),
            .hit   (hits[i].hit_exm)
        );
        fwd_match #(.REG_AW(REG_AW)) u_match_wb (
            .wr_en (wb_wr_en),
            .dst   (wb_dst),
            .src   (src_idx[i]),
            .hit   (hits[i].hit_wb)
        );
        fwd_pick u_pick (
            .hits (hits[i]),
            .sel  (sel_v[i])
        );
        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[i]),
            .rf_val  (rf_val[i]),
            .exm_val (exm_result),
            .wb_val  (wb_data),
            .y       (op_val[i])
        );
    end

    assign sel_a = sel_v[0];
    assign sel_b = sel_v[1];
    assign op_a  = op_val[0];
    assign op_b  = op_val[1];

    always_comb begin : chk
        if (!$isunknown({ex_src_a, ex_src_b, exm_wr_en, exm_dst, wb_wr_en, wb_dst})) begin
            assert_same_src_same_sel_R9: assert (ex_src_a != ex_src_b || sel_a == sel_b)
                else $error("identical sources resolved differently");
            assert_exm_hit_a_R1: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == ex_src_a) || sel_a == 2'b10)
                else $error("operand A missed memory-stage bypass");
            assert_exm_hit_b_R2: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == ex_src_b) || sel_b == 2'b10)
                else $error("operand B missed memory-stage bypass");
        end
    end
endmodule

// File: tb/fwd_unit_top_tb.sv
module fwd_unit_top_tb;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [RW-1:0] ex_src_a, ex_src_b, exm_dst, wb_dst;
    logic          exm_wr_en, wb_wr_en;
    logic [DW-1:0] rf_data_a, rf_data_b, exm_result, wb_data;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] op_a, op_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fwd_unit_top #(.REG_AW(RW), .DATA_W(DW)) u_dut (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
        .wb_wr_en(wb_wr_en), .wb_dst(wb_dst),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .exm_result(exm_result), .wb_data(wb_data),
        .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
    );

    // Behavioural reference: integer codes 0 = file, 1 = writeback, 2 = memory stage
    function automatic int ref_code(int src, int me, int md, int we, int wd);
        if (me != 0 && md != 0 && md == src) return 2;
        if (we != 0 && wd != 0 && wd == src) return 1;
        return 0;
    endfunction

    function automatic string req_of(int code, bit lane_b, bit both);
        if (code == 2) return both ? "R5" : (lane_b ? "R2" : "R1");
        if (code == 1) return lane_b ? "R4" : "R3";
        return "R8";
    endfunction

    task automatic check_lane(bit lane_b);
        int src  = lane_b ? int'(ex_src_b) : int'(ex_src_a);
        int code = ref_code(src, exm_wr_en, exm_dst, wb_wr_en, wb_dst);
        bit both = (code == 2) && wb_wr_en && wb_dst != 0 && int'(wb_dst) == src;
        logic [1:0] exp_sel = (code == 2) ? 2'b10 : (code == 1) ? 2'b01 : 2'b00;
        logic [DW-1:0] rf = lane_b ? rf_data_b : rf_data_a;
        logic [DW-1:0] exp_op = (code == 2) ? exm_result : (code == 1) ? wb_data : rf;
        logic [1:0] act_sel = lane_b ? sel_b : sel_a;
        logic [DW-1:0] act_op = lane_b ? op_b : op_a;
        string r = req_of(code, lane_b, both);
        checks++;
        if (act_sel !== exp_sel) begin
            errors++;
            $display("FAIL %s lane %0d select actual %b expected %b", r, lane_b, act_sel, exp_sel);
        end
        checks++;
        if (act_op !== exp_op) begin
            errors++;
            $display("FAIL R10 lane %0d operand actual %h expected %h", lane_b, act_op, exp_op);
        end
    endtask

    task automatic apply(int sa, int sb, int me, int md, int we, int wd);
        @(negedge clk);
        ex_src_a = RW'(sa); ex_src_b = RW'(sb);
        exm_wr_en = me[0]; exm_dst = RW'(md);
        wb_wr_en = we[0]; wb_dst = RW'(wd);
        rf_data_a = $urandom; rf_data_b = $urandom;
        exm_result = $urandom; wb_data = $urandom;
        @(posedge clk);
        #1;
        check_lane(1'b0);
        check_lane(1'b1);
    endtask

    initial begin
        ex_src_a = '0; ex_src_b = '0; exm_wr_en = 1'b0; exm_dst = '0;
        wb_wr_en = 1'b0; wb_dst = '0;
        rf_data_a = 32'h1111_0000; rf_data_b = 32'h2222_0000;
        exm_result = 32'h3333_0000; wb_data = 32'h4444_0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // R8: quiet state after reset selects the register file
        check_lane(1'b0);
        check_lane(1'b1);

        apply(2, 7, 1, 2, 0, 0);    // R1 operand A from memory stage
        apply(4, 9, 1, 9, 0, 0);    // R2 operand B from memory stage
        apply(6, 1, 0, 0, 1, 6);    // R3 operand A from writeback
        apply(3, 12, 1, 5, 1, 12);  // R4 operand B from writeback
        apply(8, 8, 1, 8, 1, 8);    // R5 and R9: both sources, both producers
        apply(0, 0, 1, 0, 1, 0);    // R6 register zero never bypassed
        apply(0, 3, 1, 0, 1, 3);    // R6 memory stage zero, writeback wins
        apply(5, 5, 0, 5, 0, 5);    // R7 write disabled never bypassed
        apply(7, 10, 0, 7, 1, 7);   // R7 disabled young producer, old wins
        apply(11, 14, 1, 11, 1, 14);// R9 A from memory stage, B from writeback
        apply(13, 15, 1, 2, 1, 4);  // R8 no match anywhere

        for (int i = 0; i < 3000; i++) begin
            apply($urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 1), $urandom_range(0, 7),
                  $urandom_range(0, 1), $urandom_range(0, 7));
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual running expected done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule